// File: doc/BRIEF.md
# DMA Global Control Register

This block is the single global control byte of a four-channel DMA controller. A simple register bus writes and reads it through one-cycle strobes. Its fields fan out as steady levels: a controller enable for the channels, a software-reset level, a per-channel double-buffer map for the address generators, and a two-bit priority-mode code for the arbiter. The datapath reports back one status bit, high when its internal transfer buffer holds no data.

Turning the controller off is graceful. Writing the enable bit to zero while running raises a one-cycle abort request. The enable bit, and the enable output, stay high until the datapath reports an empty buffer. Software reset can only be started while the controller is fully off. It clears the mode fields, holds the reset output for a fixed number of cycles, and then clears its own bit.

A four-state machine sequences this behaviour:
- OFF: disabled.
- ON: enabled.
- DRAIN: disable requested, waiting for the buffer to empty.
- SRST: software reset running.

The named transitions are:
- OFF to SRST on a write with bit 6 set.
- OFF to ON on a write with bit 7 set and bit 6 clear.
- ON to DRAIN on a write with bit 7 clear.
- DRAIN to OFF on the first cycle that buf_empty is high.
- SRST to OFF when the reset count expires.

Every other condition holds the current state.

Top module: `dmac_ctl_reg`

## Requirements
- R1: After rst_n is released, every field is 0, the register reads 0x00, and ch_enable, sw_rst, abort_req, dbuf_ch and prio_mode are all 0.
- R2: In OFF, a write with bit 7 = 1 and bit 6 = 0 sets the enable. ch_enable and read bit 7 are 1 from the cycle after the write.
- R3: In ON, a write with bit 7 = 0 raises abort_req for exactly the one cycle after the write. abort_req is high only after such a write.
- R4: After a disable request, ch_enable and read bit 7 stay 1 while buf_empty is 0. They become 0 in the cycle after the first cycle in DRAIN that has buf_empty = 1. This holds even when buf_empty is already 1 as the request arrives.
- R5: In DRAIN, writes to bit 7 and bit 6 have no effect, while bits 3:0 are still written.
- R6: While the enable is set (ON or DRAIN), writing 1 to bit 6 is ignored and sw_rst stays 0.
- R7: In OFF, a write with bit 6 = 1 clears bits 3:0. sw_rst and read bit 6 are then 1 for exactly RST_CYCLES cycles, starting in the cycle after the write, after which both return to 0. sw_rst and ch_enable are never high together.
- R8: Every write that arrives while the software reset runs is ignored.
- R9: Bits 5:4 always read 0, and writes to them have no effect.
- R10: Bits 3:2 set the double-buffer pairing and read back. dbuf_ch is 0000 for 00, 0011 for 01, 1100 for 10 and 1111 for 11 (bit n = channel n).
- R11: Bits 1:0 set prio_mode and read back unchanged.
- R12: rdata is 0x00 whenever rd_en is 0. While rd_en is 1, rdata is {enable, reset, 00, bits 3:2, bits 1:0} of the current cycle.
- R13: In OFF, a write with bits 7 and 6 both set starts a software reset and leaves the enable clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Read data, zero when not reading |
| buf_empty | input | 1 | Datapath transfer buffer holds no data |
| ch_enable | output | 1 | Controller enable to the channels |
| abort_req | output | 1 | One-cycle request to abort the running transfer |
| sw_rst | output | 1 | Software reset level to the channels |
| dbuf_ch | output | 4 | Per-channel double-buffer enable |
| prio_mode | output | 2 | Priority-mode code to the arbiter |

## Verification
The bench builds the block with RST_CYCLES = 4. This keeps the reset window short enough to do two things in one run: count the whole window cycle by cycle, and land writes and a read inside it. One disable is drained with buf_empty low, so the abort pulse and the held enable can be seen apart. A second disable is made with buf_empty already high, which gives the shortest path back to OFF. All four double-buffer codes are driven. The combined enable-and-reset write shows which of the two wins.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_CH   = 4;
    localparam int PAIR_N   = NUM_CH / 2;
    localparam int BIT_EN   = 7;
    localparam int BIT_SRST = 6;
    localparam int DBUF_LSB = 2;
    localparam int PRIO_LSB = 0;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_DRAIN = 2'd2,
        ST_SRST  = 2'd3
    } ctl_state_t;

    typedef struct packed {
        logic [PAIR_N-1:0] dbuf;
        logic [1:0]        prio;
    } ctl_fields_t;

endpackage

// File: rtl/dmac_ctl_fsm.sv
module dmac_ctl_fsm
    import dmac_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_en_bit,
    input  logic       wr_srst_bit,
    input  logic       buf_empty,
    output ctl_state_t state,
    output logic       abort_q,
    output logic       fields_we,
    output logic       fields_clr
);

    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    ctl_state_t       state_nx;
    logic [CNT_W-1:0] cnt_q;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (wr_en && wr_srst_bit)
                    state_nx = ST_SRST;        // reset wins over enable (R13)
                else if (wr_en && wr_en_bit)
                    state_nx = ST_ON;
            end
            ST_ON: begin
                if (wr_en && !wr_en_bit)
                    state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (buf_empty)
                    state_nx = ST_OFF;
            end
            ST_SRST: begin
                if (cnt_q == '0)
                    state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // state register and reset-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            if (state != ST_SRST && state_nx == ST_SRST)
                cnt_q <= CNT_LOAD;
            else if (state == ST_SRST && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            abort_q <= 1'b0;
        else
            abort_q <= (state == ST_ON) && wr_en && !wr_en_bit;
    end

    always_comb begin
        fields_clr = (state == ST_OFF) && wr_en && wr_srst_bit;
        fields_we  = wr_en && (state != ST_SRST) && !fields_clr;
    end

endmodule

// File: rtl/dmac_ctl_fields.sv
module dmac_ctl_fields
    import dmac_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        clr,
    input  ctl_fields_t wr_val,
    output ctl_fields_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (we)
            q <= wr_val;
    end

endmodule

// File: rtl/dmac_ctl_dbuf_map.sv
module dmac_ctl_dbuf_map
    import dmac_ctl_pkg::*;
(
    input  logic [PAIR_N-1:0] pair_sel,
    output logic [NUM_CH-1:0] ch_dbuf
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_dbuf[c] = pair_sel[c / 2];
    end

endmodule

// File: rtl/dmac_ctl_reg.sv
module dmac_ctl_reg
    import dmac_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    input  logic              buf_empty,
    output logic              ch_enable,
    output logic              abort_req,
    output logic              sw_rst,
    output logic [NUM_CH-1:0] dbuf_ch,
    output logic [1:0]        prio_mode
);

    ctl_state_t  state;
    ctl_fields_t fld_q;
    ctl_fields_t fld_wr;
    logic        fld_we;
    logic        fld_clr;
    logic        unused_rsv;

    assign unused_rsv    = ^wdata[5:4];
    assign fld_wr.dbuf   = wdata[DBUF_LSB +: PAIR_N];
    assign fld_wr.prio   = wdata[PRIO_LSB +: 2];

    dmac_ctl_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_en_bit  (wdata[BIT_EN]),
        .wr_srst_bit(wdata[BIT_SRST]),
        .buf_empty  (buf_empty),
        .state      (state),
        .abort_q    (abort_req),
        .fields_we  (fld_we),
        .fields_clr (fld_clr)
    );

    dmac_ctl_fields u_fields (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fld_we),
        .clr   (fld_clr),
        .wr_val(fld_wr),
        .q     (fld_q)
    );

    dmac_ctl_dbuf_map u_map (
        .pair_sel(fld_q.dbuf),
        .ch_dbuf (dbuf_ch)
    );

    always_comb begin
        ch_enable = (state == ST_ON) || (state == ST_DRAIN);
        sw_rst    = (state == ST_SRST);
        prio_mode = fld_q.prio;
        rdata     = '0;
        if (rd_en) begin
            rdata[BIT_EN]                = ch_enable;
            rdata[BIT_SRST]              = sw_rst;
            rdata[DBUF_LSB +: PAIR_N]    = fld_q.dbuf;
            rdata[PRIO_LSB +: 2]         = fld_q.prio;
        end
    end

endmodule

// File: rtl/dmac_ctl_chk.sv
module dmac_ctl_chk
    import dmac_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_en_bit,
    input logic              rd_en,
    input logic [REG_W-1:0]  rdata,
    input logic              buf_empty,
    input logic              ch_enable,
    input logic              abort_req,
    input logic              sw_rst,
    input logic [NUM_CH-1:0] dbuf_ch
);

    localparam int RW = $clog2(RST_CYCLES + 2) + 1;
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (sw_rst && run_cnt != '1)
            run_cnt <= run_cnt + 1'b1;
        else if (!sw_rst)
            run_cnt <= '0;
    end

    p_abort_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_req) |-> $past(wr_en && !wr_en_bit && ch_enable));

    p_en_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_enable) |-> $past(buf_empty));

    p_srst_from_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_rst) |-> $past(!ch_enable));

    p_srst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rst) |-> run_cnt == RW'(RST_CYCLES));

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_rst && ch_enable));

    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[5:4] == 2'b00);

    p_pairs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_ch[0] == dbuf_ch[1]) && (dbuf_ch[2] == dbuf_ch[3]));

    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

endmodule

bind dmac_ctl_reg dmac_ctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_en_bit (wdata[7]),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .buf_empty (buf_empty),
    .ch_enable (ch_enable),
    .abort_req (abort_req),
    .sw_rst    (sw_rst),
    .dbuf_ch   (dbuf_ch)
);

// File: tb/dmac_ctl_reg_tb.sv
module dmac_ctl_reg_tb;

    localparam int RST_CYCLES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       buf_empty = 1'b0;
    logic       ch_enable;
    logic       abort_req;
    logic       sw_rst;
    logic [3:0] dbuf_ch;
    logic [1:0] prio_mode;

    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    dmac_ctl_reg #(.RST_CYCLES(RST_CYCLES)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .buf_empty(buf_empty),
        .ch_enable(ch_enable),
        .abort_req(abort_req),
        .sw_rst   (sw_rst),
        .dbuf_ch  (dbuf_ch),
        .prio_mode(prio_mode)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = b;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = 8'h00;
    endtask

    // driver: pushes the expected read value into the scoreboard
    task automatic rd(input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_srst_done();
        for (int i = 0; i < 64 && sw_rst === 1'b1; i++) @(negedge clk);
    endtask

    // monitor: pops and compares as reads happen
    always @(negedge clk) begin : mon
        logic [7:0] e;
        string      t;
        #2;
        if (rd_en === 1'b1 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 enable", {7'd0, ch_enable}, 8'h00);
        check("R1 sw_rst", {7'd0, sw_rst}, 8'h00);
        check("R1 abort", {7'd0, abort_req}, 8'h00);
        check("R1 dbuf/prio", {2'd0, dbuf_ch, prio_mode}, 8'h00);
        rd(8'h00, "R1 read");

        // R9 R10 R11 field writes
        wr(8'h3B);
        check("R10 dbuf 10", {4'd0, dbuf_ch}, 8'h0C);
        check("R11 prio 11", {6'd0, prio_mode}, 8'h03);
        rd(8'h0B, "R9 reserved ignored");
        wr(8'h06);
        check("R10 dbuf 01", {4'd0, dbuf_ch}, 8'h03);
        check("R11 prio 10", {6'd0, prio_mode}, 8'h02);
        wr(8'h0D);
        check("R10 dbuf 11", {4'd0, dbuf_ch}, 8'h0F);
        rd(8'h0D, "R10 readback");
        wr(8'h00);
        check("R10 dbuf 00", {4'd0, dbuf_ch}, 8'h00);
        wr(8'h05);
        // R12 idle read
        @(negedge clk);
        check("R12 rdata idle", rdata, 8'h00);

        // R2 enable
        wr(8'h85);
        check("R2 enable", {7'd0, ch_enable}, 8'h01);
        rd(8'h85, "R2 read");

        // R6 reset ignored while enabled
        wr(8'hC5);
        check("R6 sw_rst", {7'd0, sw_rst}, 8'h00);
        rd(8'h85, "R6 read");

        // R3 R4 disable with buffer busy
        buf_empty = 1'b0;
        wr(8'h05);
        check("R3 abort pulse", {7'd0, abort_req}, 8'h01);
        check("R4 enable held", {7'd0, ch_enable}, 8'h01);
        @(negedge clk);
        check("R3 abort one cycle", {7'd0, abort_req}, 8'h00);
        rd(8'h85, "R4 read while draining");
        // R5 writes in DRAIN: enable/reset bits ignored, fields updated
        wr(8'hC7);
        check("R5 sw_rst", {7'd0, sw_rst}, 8'h00);
        check("R5 abort none", {7'd0, abort_req}, 8'h00);
        rd(8'h87, "R5 read");
        repeat (3) @(negedge clk);
        check("R4 still held", {7'd0, ch_enable}, 8'h01);
        buf_empty = 1'b1;
        @(negedge clk);
        check("R4 cleared", {7'd0, ch_enable}, 8'h00);
        rd(8'h07, "R4 read off");

        // R7 software reset length, R8 write ignored during reset
        wr(8'h40);
        n = 0;
        while (sw_rst === 1'b1 && n < 64) begin
            n++;
            @(negedge clk);
        end
        check("R7 reset length", 8'(n), 8'(RST_CYCLES));
        rd(8'h00, "R7 fields cleared");

        wr(8'h07);
        wr(8'h40);
        wr(8'h8F);
        rd(8'h40, "R7 reset bit reads 1");
        wait_srst_done();
        check("R8 enable", {7'd0, ch_enable}, 8'h00);
        rd(8'h00, "R8 read after reset");

        // R13 reset wins over enable
        wr(8'hC0);
        check("R13 sw_rst", {7'd0, sw_rst}, 8'h01);
        check("R13 enable", {7'd0, ch_enable}, 8'h00);
        wait_srst_done();
        rd(8'h00, "R13 read");

        // R4 disable with buffer already empty
        buf_empty = 1'b1;
        wr(8'h81);
        wr(8'h01);
        check("R4 fast held", {7'd0, ch_enable}, 8'h01);
        check("R3 fast abort", {7'd0, abort_req}, 8'h01);
        @(negedge clk);
        check("R4 fast cleared", {7'd0, ch_enable}, 8'h00);
        rd(8'h01, "R4 fast read");

        for (int i = 0; i < 16 && exp_q.size() > 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule